// File: doc/BRIEF.md
# Two-Line Serial Audio Input Receiver

This block receives serial audio on two data lines that share one bit clock and one word-select input. It works only as a slave: the bit clock and word select come from outside. All serial inputs pass through synchronisers in the system clock domain, and the system clock must run at least four times faster than the bit clock. The receiver samples data on each rising edge of the bit clock. A word-select low slot carries the left channel and a word-select high slot carries the right channel.

Two framings are supported and are chosen with a format input. In the first, data is MSB-first and the MSB arrives one bit clock after the word-select change. In the second, data is right-justified: the LSB is the last bit before the word-select change. A payload input selects between two modes. Coded mode yields 16-bit words. PCM mode yields samples of 16, 18 or 20 bits. Every result is widened to a 20-bit output per channel and per line. A one-cycle strobe marks each completed left/right pair.

Top module: `serial_audio_rx`

## Requirements
- R1: Both data lines are sampled on the same bit-clock rising edges and the same word-select value. Each line delivers its own left and right word in the same strobe cycle; line k sits in output bits [20k+19:20k].
- R2: With `fmt_i`=0 (MSB-first, delayed), the bit sampled on the rise where word select has changed is the final bit of the previous slot. The next rise carries the MSB of the new slot. Word select 0 marks the left channel and 1 marks the right channel.
- R3: With `fmt_i`=1 (right-justified), a slot's word is the last N bits sampled before the rise on which word select changes, with the last of those bits as the LSB. N is the active word length.
- R4: With `pcm_i`=0 (coded), N is 16. In delayed framing, the first 16 bits of a slot are kept and later bits are discarded. Output bits 19..16 are zero.
- R5: With `pcm_i`=1, N follows `wlen_i`: 0 gives 16, 1 gives 18, 2 or 3 gives 20. Slot bits after the Nth are discarded in delayed framing. The sample is right-aligned and sign-extended from bit N-1 to bit 19.
- R6: `pair_valid_o` rises for exactly one cycle after a right slot ends, provided a left slot was captured before it. The left and right outputs change only in that cycle and hold between strobes.
- R7: After reset, a slot that began before the first observed word-select change is discarded. A right slot with no captured left slot before it produces no strobe.
- R8: While `rst` is high and in the cycle after it, `pair_valid_o` is 0. Reset clears the outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | External serial bit clock |
| lrck_i | input | 1 | Word select: 0 left, 1 right |
| sd_i | input | LINES | Serial data, one bit per line |
| fmt_i | input | 1 | 0 MSB-first delayed, 1 right-justified |
| pcm_i | input | 1 | 0 coded 16-bit words, 1 PCM samples |
| wlen_i | input | 2 | PCM word length select |
| pair_valid_o | output | 1 | One-cycle strobe for a completed pair |
| left_o | output | LINES*MAX_W | Left words, 20 bits per line |
| right_o | output | LINES*MAX_W | Right words, 20 bits per line |

## Verification
The bench uses the default parameters: two lines, a 20-bit maximum width, a 16-bit coded width and two synchroniser stages. With these values every word length can be selected, including the full 20 bits and sign extension from bits 15, 17 and 19. Slot lengths of 16, 20, 24 and 32 bit clocks show the tightest slot for each length and the discarding of surplus bits. The two lines always carry different words, so a swapped or shared lane shows up as a data mismatch.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  typedef enum logic {
    FMT_DELAYED = 1'b0,
    FMT_RJ      = 1'b1
  } sarx_fmt_e;

  typedef enum logic [1:0] {
    WL_SHORT = 2'd0,
    WL_MID   = 2'd1,
    WL_FULL  = 2'd2,
    WL_FULL2 = 2'd3
  } sarx_wlen_e;

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_i,
  input  logic             lrck_i,
  input  logic [LINES-1:0] sd_i,
  output logic             bit_stb_o,
  output logic             ws_o,
  output logic [LINES-1:0] sd_o
);

  // the clock chain has one extra stage for rising-edge detection
  logic [STAGES:0]   bclk_q;
  logic [STAGES-1:0] lrck_q;
  logic [LINES-1:0]  sd_q [STAGES];
  logic              rise;

  assign rise = bclk_q[STAGES-1] & ~bclk_q[STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q    <= '0;
      lrck_q    <= '0;
      bit_stb_o <= 1'b0;
      ws_o      <= 1'b0;
      sd_o      <= '0;
      for (int s = 0; s < STAGES; s++) sd_q[s] <= '0;
    end else begin
      bclk_q <= {bclk_q[STAGES-1:0], bclk_i};
      lrck_q <= {lrck_q[STAGES-2:0], lrck_i};
      sd_q[0] <= sd_i;
      for (int s = 1; s < STAGES; s++) sd_q[s] <= sd_q[s-1];
      bit_stb_o <= rise;
      if (rise) begin
        ws_o <= lrck_q[STAGES-1];
        sd_o <= sd_q[STAGES-1];
      end
    end
  end

endmodule

// File: rtl/sarx_frame_ctrl.sv
module sarx_frame_ctrl
  import sarx_pkg::*;
#(
  parameter int MAX_W   = 20,
  parameter int CODED_W = 16,
  localparam int LEN_W  = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb_i,
  input  logic             ws_i,
  input  logic             pcm_i,
  input  logic [1:0]       wlen_i,
  output logic [LEN_W-1:0] eff_len_o,
  output logic             shift_en_o,
  output logic             slot_end_o,
  output logic             cap_left_o,
  output logic             cap_right_o,
  output logic             pair_valid_o
);

  logic             ws_prev;
  logic             ws_seen;
  logic             armed;
  logic             have_left;
  logic [LEN_W-1:0] bit_cnt;
  logic [LEN_W-1:0] pcm_len;

  always_comb begin
    case (sarx_wlen_e'(wlen_i))
      WL_SHORT: pcm_len = LEN_W'(MAX_W - 4);
      WL_MID:   pcm_len = LEN_W'(MAX_W - 2);
      default:  pcm_len = LEN_W'(MAX_W);
    endcase
    eff_len_o = pcm_i ? pcm_len : LEN_W'(CODED_W);
  end

  assign slot_end_o  = bit_stb_i & ws_seen & (ws_i != ws_prev);
  assign cap_left_o  = slot_end_o & armed & ~ws_prev;
  assign cap_right_o = slot_end_o & armed & ws_prev & have_left;
  assign shift_en_o  = bit_cnt < eff_len_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_prev      <= 1'b0;
      ws_seen      <= 1'b0;
      armed        <= 1'b0;
      have_left    <= 1'b0;
      bit_cnt      <= '0;
      pair_valid_o <= 1'b0;
    end else begin
      pair_valid_o <= cap_right_o;
      if (bit_stb_i) begin
        ws_prev <= ws_i;
        ws_seen <= 1'b1;
        if (slot_end_o) begin
          armed   <= 1'b1;
          bit_cnt <= '0;
        end else if (shift_en_o) begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (cap_left_o)       have_left <= 1'b1;
      else if (cap_right_o) have_left <= 1'b0;
    end
  end

endmodule

// File: rtl/sarx_lane.sv
module sarx_lane
  import sarx_pkg::*;
#(
  parameter int MAX_W  = 20,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb_i,
  input  logic             sd_i,
  input  logic             fmt_i,
  input  logic             pcm_i,
  input  logic [LEN_W-1:0] eff_len_i,
  input  logic             shift_en_i,
  input  logic             slot_end_i,
  input  logic             cap_left_i,
  input  logic             cap_right_i,
  output logic [MAX_W-1:0] left_o,
  output logic [MAX_W-1:0] right_o
);

  logic [MAX_W-1:0] shreg;
  logic [MAX_W-1:0] shifted;
  logic [MAX_W-1:0] raw;
  logic [MAX_W-1:0] word;
  logic [MAX_W-1:0] left_hold;
  logic [LEN_W-1:0] sign_idx;
  logic             sign_b;
  logic             is_rj;

  assign is_rj   = (fmt_i == FMT_RJ);
  assign shifted = {shreg[MAX_W-2:0], sd_i};

  always_comb begin
    // right-justified framing ends the word before the current bit;
    // delayed framing includes the current bit while room remains
    raw      = (is_rj || !shift_en_i) ? shreg : shifted;
    sign_idx = eff_len_i - 1'b1;
    sign_b   = raw[sign_idx];
    for (int i = 0; i < MAX_W; i++) begin
      word[i] = (LEN_W'(i) < eff_len_i) ? raw[i] : (pcm_i & sign_b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
    end else begin
      if (bit_stb_i) begin
        if (is_rj)           shreg <= shifted;
        else if (slot_end_i) shreg <= '0;
        else if (shift_en_i) shreg <= shifted;
      end
      if (cap_left_i) left_hold <= word;
      if (cap_right_i) begin
        left_o  <= left_hold;
        right_o <= word;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int LINES       = 2,
  parameter int MAX_W       = 20,
  parameter int CODED_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bclk_i,
  input  logic                   lrck_i,
  input  logic [LINES-1:0]       sd_i,
  input  logic                   fmt_i,
  input  logic                   pcm_i,
  input  logic [1:0]             wlen_i,
  output logic                   pair_valid_o,
  output logic [LINES*MAX_W-1:0] left_o,
  output logic [LINES*MAX_W-1:0] right_o
);

  localparam int LEN_W = $clog2(MAX_W + 1);

  logic             bit_stb;
  logic             ws_bit;
  logic [LINES-1:0] sd_bits;
  logic [LEN_W-1:0] eff_len;
  logic             shift_en;
  logic             slot_end;
  logic             cap_left;
  logic             cap_right;

  sarx_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .bclk_i    (bclk_i),
    .lrck_i    (lrck_i),
    .sd_i      (sd_i),
    .bit_stb_o (bit_stb),
    .ws_o      (ws_bit),
    .sd_o      (sd_bits)
  );

  sarx_frame_ctrl #(.MAX_W(MAX_W), .CODED_W(CODED_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .bit_stb_i    (bit_stb),
    .ws_i         (ws_bit),
    .pcm_i        (pcm_i),
    .wlen_i       (wlen_i),
    .eff_len_o    (eff_len),
    .shift_en_o   (shift_en),
    .slot_end_o   (slot_end),
    .cap_left_o   (cap_left),
    .cap_right_o  (cap_right),
    .pair_valid_o (pair_valid_o)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_lane
    sarx_lane #(.MAX_W(MAX_W)) u_lane (
      .clk         (clk),
      .rst         (rst),
      .bit_stb_i   (bit_stb),
      .sd_i        (sd_bits[g]),
      .fmt_i       (fmt_i),
      .pcm_i       (pcm_i),
      .eff_len_i   (eff_len),
      .shift_en_i  (shift_en),
      .slot_end_i  (slot_end),
      .cap_left_i  (cap_left),
      .cap_right_i (cap_right),
      .left_o      (left_o[g*MAX_W +: MAX_W]),
      .right_o     (right_o[g*MAX_W +: MAX_W])
    );
  end

endmodule

// File: rtl/sarx_checks.sv
module sarx_checks #(
  parameter int LINES   = 2,
  parameter int MAX_W   = 20,
  parameter int CODED_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   pcm_i,
  input logic [1:0]             wlen_i,
  input logic                   pair_valid_o,
  input logic [LINES*MAX_W-1:0] left_o,
  input logic [LINES*MAX_W-1:0] right_o
);

  localparam int PAD_W  = MAX_W - CODED_W;
  localparam int SHORT_W = MAX_W - 4;
  localparam int EXT_W  = MAX_W - SHORT_W + 1;

  logic pad_zero;
  logic short_ext;

  always_comb begin
    pad_zero  = 1'b1;
    short_ext = 1'b1;
    for (int l = 0; l < LINES; l++) begin
      if (left_o[l*MAX_W+CODED_W +: PAD_W] != '0)  pad_zero = 1'b0;
      if (right_o[l*MAX_W+CODED_W +: PAD_W] != '0) pad_zero = 1'b0;
      if (left_o[l*MAX_W+SHORT_W-1 +: EXT_W] != '0 &&
          left_o[l*MAX_W+SHORT_W-1 +: EXT_W] != '1) short_ext = 1'b0;
      if (right_o[l*MAX_W+SHORT_W-1 +: EXT_W] != '0 &&
          right_o[l*MAX_W+SHORT_W-1 +: EXT_W] != '1) short_ext = 1'b0;
    end
  end

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    pair_valid_o |=> !pair_valid_o);

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
    !pair_valid_o |-> ($stable(left_o) && $stable(right_o)));

  assert_coded_pad_R4: assert property (@(posedge clk) disable iff (rst)
    (pair_valid_o && !pcm_i) |-> pad_zero);

  assert_short_sign_R5: assert property (@(posedge clk) disable iff (rst)
    (pair_valid_o && pcm_i && wlen_i == 2'd0) |-> short_ext);

  assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pair_valid_o);

endmodule

bind serial_audio_rx sarx_checks #(
  .LINES(LINES), .MAX_W(MAX_W), .CODED_W(CODED_W)
) u_checks (
  .clk          (clk),
  .rst          (rst),
  .pcm_i        (pcm_i),
  .wlen_i       (wlen_i),
  .pair_valid_o (pair_valid_o),
  .left_o       (left_o),
  .right_o      (right_o)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;

  localparam int LINES = 2;
  localparam int MW    = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rst = 1'b1;
  logic                bclk = 1'b0;
  logic                lrck = 1'b0;
  logic [LINES-1:0]    sd = '0;
  logic                fmt = 1'b0;
  logic                pcm = 1'b0;
  logic [1:0]          wlen = 2'd0;
  logic                pair_valid;
  logic [LINES*MW-1:0] left_w;
  logic [LINES*MW-1:0] right_w;

  serial_audio_rx u_serial_audio_rx (
    .clk          (clk),
    .rst          (rst),
    .bclk_i       (bclk),
    .lrck_i       (lrck),
    .sd_i         (sd),
    .fmt_i        (fmt),
    .pcm_i        (pcm),
    .wlen_i       (wlen),
    .pair_valid_o (pair_valid),
    .left_o       (left_w),
    .right_o      (right_w)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [79:0] exp_q[$];
  string       tag_q[$];
  logic [1:0]  dly = '0;
  logic [79:0] last_exp = '0;

  task automatic chk(input bit ok, input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nlen(input logic p, input logic [1:0] wl);
    if (!p) return 16;
    if (wl == 2'd0) return 16;
    if (wl == 2'd1) return 18;
    return 20;
  endfunction

  function automatic logic [MW-1:0] expect_word(input logic [23:0] w, input int W);
    int n;
    logic [23:0] v;
    logic [MW-1:0] r;
    n = nlen(pcm, wlen);
    if (!fmt) v = (W >= n) ? (w >> (W - n)) : (w << (n - W));
    else      v = w;
    for (int i = 0; i < MW; i++) r[i] = (i < n) ? v[i] : (pcm & v[n-1]);
    return r;
  endfunction

  function automatic logic slot_bit(input logic [23:0] w, input int W, input int S, input int p);
    if (!fmt) return (p < W) ? w[W-1-p] : 1'b0;
    return (p >= S - W) ? w[S-1-p] : 1'b0;
  endfunction

  task automatic tick(input logic ws, input logic [1:0] b);
    @(negedge clk);
    bclk = 1'b0;
    lrck = ws;
    if (fmt) sd = b;
    else begin
      sd  = dly;
      dly = b;
    end
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_slot(input logic ws, input logic [23:0] w0, input logic [23:0] w1, input int W, input int S);
    for (int p = 0; p < S; p++) tick(ws, {slot_bit(w1, W, S, p), slot_bit(w0, W, S, p)});
  endtask

  // driver: sends a frame and pushes the expected pair into the scoreboard
  task automatic send_frame(input logic [23:0] l0, input logic [23:0] l1, input logic [23:0] r0,
                            input logic [23:0] r1, input int W, input int S, input string tag);
    logic [23:0] m;
    m = (24'h1 << W) - 24'h1;
    if (W == 24) m = 24'hFFFFFF;
    send_slot(1'b0, l0 & m, l1 & m, W, S);
    send_slot(1'b1, r0 & m, r1 & m, W, S);
    exp_q.push_back({expect_word(l0 & m, W), expect_word(l1 & m, W),
                     expect_word(r0 & m, W), expect_word(r1 & m, W)});
    tag_q.push_back(tag);
  endtask

  task automatic run_phase(input logic f, input logic p, input logic [1:0] wl,
                           input int W, input int S, input string tag);
    rst  = 1'b1;
    fmt  = f;
    pcm  = p;
    wlen = wl;
    dly  = '0;
    lrck = 1'b0;
    bclk = 1'b0;
    sd   = '0;
    repeat (6) @(negedge clk);
    // R8: quiet, cleared outputs while in reset
    chk(pair_valid == 1'b0, "R8 strobe in reset", {19'd0, pair_valid}, '0);
    chk(left_w[MW-1:0] == '0, "R8 left cleared", left_w[MW-1:0], '0);
    rst = 1'b0;
    // R7: partial left and unpaired right after reset must not strobe
    send_slot(1'b0, 24'hFFFFFF, 24'hFFFFFF, 24, S);
    send_slot(1'b1, 24'hFFFFFF, 24'hFFFFFF, 24, S);
    send_frame(24'h9A5C3E, 24'h3C96F1, 24'hF00F81, 24'h0E1D2B, W, S, tag);
    send_frame(24'h800001, 24'h7FFFFE, 24'hFFFFFF, 24'h000000, W, S, tag);
    send_frame(24'hC35A69, 24'h1B2E4D, 24'hA5A5A5, 24'h5A5A5A, W, S, tag);
    // flush slot closes the last right slot
    send_slot(1'b0, 24'h000000, 24'h000000, W, S);
    repeat (40) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 missing pairs: actual %0d pending expected 0", exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
    // R6: outputs still hold the last pair
    chk(left_w[MW-1:0] == last_exp[79:60], "R6 hold left", left_w[MW-1:0], last_exp[79:60]);
    chk(right_w[2*MW-1:MW] == last_exp[19:0], "R6 hold right", right_w[2*MW-1:MW], last_exp[19:0]);
  endtask

  // monitor: pops the scoreboard on each strobe
  initial begin : monitor
    bit prev_v;
    prev_v = 0;
    forever begin
      @(negedge clk);
      if (rst) prev_v = 0;
      else if (pair_valid) begin
        if (prev_v) begin
          checks++;
          errors++;
          $display("FAIL R6 strobe wider than one cycle: actual 2 expected 1");
        end
        prev_v = 1;
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R7 unexpected pair: actual %h expected none", left_w);
        end else begin
          logic [79:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          chk(left_w[MW-1:0] == e[79:60], {t, " lane0 left"}, left_w[MW-1:0], e[79:60]);
          // R1: second line carries its own words in the same strobe
          chk(left_w[2*MW-1:MW] == e[59:40], {t, " R1 lane1 left"}, left_w[2*MW-1:MW], e[59:40]);
          chk(right_w[MW-1:0] == e[39:20], {t, " lane0 right"}, right_w[MW-1:0], e[39:20]);
          chk(right_w[2*MW-1:MW] == e[19:0], {t, " R1 lane1 right"}, right_w[2*MW-1:MW], e[19:0]);
        end
      end else prev_v = 0;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog: actual no completion expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    run_phase(1'b0, 1'b0, 2'd0, 16, 16, "R2 R4 32fs coded");
    run_phase(1'b0, 1'b0, 2'd0, 24, 32, "R2 R4 coded truncation");
    run_phase(1'b0, 1'b1, 2'd2, 20, 32, "R2 R5 pcm20");
    run_phase(1'b0, 1'b1, 2'd1, 24, 32, "R5 pcm18 truncation");
    run_phase(1'b0, 1'b1, 2'd3, 20, 20, "R5 pcm20 tight slot");
    run_phase(1'b1, 1'b1, 2'd0, 16, 32, "R3 R5 rj pcm16");
    run_phase(1'b1, 1'b1, 2'd2, 20, 24, "R3 rj pcm20");
    run_phase(1'b1, 1'b0, 2'd0, 20, 32, "R3 R4 rj coded");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule